// File: doc/BRIEF.md
# Input Pulse-Width and Period Capture Channel

This channel timestamps transitions of an asynchronous digital input against a free-running timebase supplied on a port, and turns pairs of timestamps into a measurement. In width mode it records the time of the opening edge and the time of the following opposite edge. It posts the active width once per input period. In period mode it records two consecutive edges of the same polarity and posts the time between them. Each closing edge also serves as the opening edge of the next period. A result register holds the latest measurement. A valid flag marks a fresh result and clears when the consumer pulses the read strobe.

Two event sub-modes share the same front end. The edge-count mode starts from a programmable initial value and counts qualifying input edges. When an edge arrives while the count sits at a programmable maximum, the count reloads to the initial value and a sticky overflow flag is raised. The edge-detect mode emits a one-cycle pulse for every qualifying edge. The `start_pol` input selects the qualifying (opening) edge in every mode: 1 selects rising, 0 selects falling.

The measurement sequencer has three states. OFF is held while the channel is disabled or in an event mode. WAIT_OPEN waits for the opening edge. WAIT_CLOSE holds the opening timestamp. The transitions are:
- arm (OFF to WAIT_OPEN): the channel is enabled in a measurement mode.
- open (WAIT_OPEN to WAIT_CLOSE): an opening edge is seen.
- close (WAIT_CLOSE to WAIT_OPEN): the opposite edge is seen, in width mode.
- restart (WAIT_CLOSE to WAIT_CLOSE): an opening edge closes one period and opens the next, in period mode.
- disarm (any state to OFF): the channel is disabled or switched to an event mode.

Top module: `icap_channel`

## Requirements
- R1: After reset, `meas_rdy`, `meas_val`, `ecnt_ovf` and `edge_evt` are all 0.
- R2: The input passes through two synchronizer flops. A transition set up before clock edge k is acted on at clock edge k+2, so in edge-detect mode `edge_evt` is high in the cycle after edge k+2 and low in the two cycles before it.
- R3: Width mode (`mode` = 2'b00) reports closing timestamp minus opening timestamp. This is the high time when `start_pol`=1 and the low time when `start_pol`=0. Exactly one result is posted per input period, on the closing edge.
- R4: `meas_val` changes only when a measurement completes, and `meas_rdy` is then set. During an active phase, the previous width stays visible and no result is flagged, so a new width appears one period late.
- R5: Period mode (`mode` = 2'b01) reports the time between successive opening edges. Every opening edge after the first posts one result.
- R6: Differences are taken modulo 2^CNT_W, so a measurement shorter than one timebase cycle is correct even when the timebase wraps between the two edges.
- R7: A pulse on `rd_ack` clears `meas_rdy` at the next clock edge, unless a measurement completes on that same edge. `rd_ack` also clears `ecnt_ovf`.
- R8: In edge-count mode (`mode` = 2'b10), `ecnt` equals `cnt_init` while the channel is disabled or in another mode. Once enabled, it increments by one on each qualifying edge.
- R9: In edge-count mode, a qualifying edge that arrives while `ecnt` equals `cnt_max` reloads `ecnt` to `cnt_init` and sets `ecnt_ovf`.
- R10: `ecnt_ovf` is never set in the width, period or edge-detect modes.
- R11: Edges that occur while `en` is 0 are neither counted, captured nor flagged.
- R12: In edge-detect mode (`mode` = 2'b11), each qualifying edge produces exactly one single-cycle `edge_evt` pulse. Edges of the other polarity produce none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Channel enable |
| mode | input | 2 | 00 width, 01 period, 10 edge count, 11 edge detect |
| start_pol | input | 1 | Qualifying/opening edge: 1 rising, 0 falling |
| sig_in | input | 1 | Asynchronous measured input |
| tbase | input | CNT_W | Free-running timebase value |
| cnt_init | input | CNT_W | Edge-count start and reload value |
| cnt_max | input | CNT_W | Edge-count maximum |
| rd_ack | input | 1 | Read strobe; clears the valid and overflow flags |
| meas_val | output | CNT_W | Latest width or period result |
| meas_rdy | output | 1 | Result valid flag |
| ecnt | output | CNT_W | Edge counter value |
| ecnt_ovf | output | 1 | Sticky edge-counter overflow flag |
| edge_evt | output | 1 | One-cycle pulse per qualifying edge in detect mode |

## Verification
The embedded properties guard the following rules on every cycle:
- the result only moves when the valid flag comes up;
- a result can only rise out of WAIT_CLOSE;
- the read strobe drops the flag;
- overflow is raised only from edge-count mode and always coincides with a reload to the initial value;
- detect pulses and captures are gated by enable;
- the synchronizer delay holds.

Only the bench scenarios can show that the measured numbers are right. These scenarios cover:
- widths of both polarities;
- a sequence of differing periods;
- a measurement spanning a timebase wrap;
- the one-period reporting delay;
- the exact pulse cycle of an edge;
- the count sequence up to and across the maximum.

// File: rtl/icap_pkg.sv
package icap_pkg;

    typedef enum logic [1:0] {
        MODE_WIDTH  = 2'b00,
        MODE_PERIOD = 2'b01,
        MODE_COUNT  = 2'b10,
        MODE_DETECT = 2'b11
    } icap_mode_e;

    typedef enum logic [1:0] {
        ST_OFF        = 2'b00,
        ST_WAIT_OPEN  = 2'b01,
        ST_WAIT_CLOSE = 2'b10
    } meas_state_e;

endpackage

// File: rtl/icap_sync_edge.sv
module icap_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    localparam int LAST = STAGES - 1;

    // pipe[0..LAST] synchronizes, pipe[STAGES] holds the previous synchronized level
    logic [STAGES:0] pipe;

    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[LAST:0], din};
    end

    assign rise = pipe[LAST] & ~pipe[STAGES];
    assign fall = ~pipe[LAST] & pipe[STAGES];

    // R2
    sync_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> $past(din, 2));

endmodule

// File: rtl/icap_meas_fsm.sv
module icap_meas_fsm
    import icap_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             period_mode,
    input  logic             open_edge,
    input  logic             close_edge,
    input  logic             rd_ack,
    input  logic [CNT_W-1:0] tbase,
    output logic             rdy,
    output logic [CNT_W-1:0] result
);
    meas_state_e      state, state_nx;
    logic [CNT_W-1:0] t_open;
    logic             take_open, take_close;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF:        if (active) state_nx = ST_WAIT_OPEN;
            ST_WAIT_OPEN:  if (!active) state_nx = ST_OFF;
                           else if (open_edge) state_nx = ST_WAIT_CLOSE;
            ST_WAIT_CLOSE: if (!active) state_nx = ST_OFF;
                           else if (!period_mode && close_edge) state_nx = ST_WAIT_OPEN;
            default:       state_nx = ST_OFF;
        endcase
    end

    assign take_open  = active && open_edge &&
                        (state == ST_WAIT_OPEN || (state == ST_WAIT_CLOSE && period_mode));
    assign take_close = active && (state == ST_WAIT_CLOSE) &&
                        (period_mode ? open_edge : close_edge);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_open <= '0;
            result <= '0;
            rdy    <= 1'b0;
        end else begin
            if (take_open)  t_open <= tbase;
            if (take_close) result <= tbase - t_open;
            rdy <= take_close | (rdy & ~rd_ack);
        end
    end

    // R4
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> rdy);

    // R7
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && state != ST_WAIT_CLOSE) |=> !rdy);

    // R3
    close_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy) |-> $past(state) == ST_WAIT_CLOSE);

    // R11
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> $stable(result));

endmodule

// File: rtl/icap_event_unit.sv
module icap_event_unit
    import icap_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  icap_mode_e       mode,
    input  logic             qual_edge,
    input  logic             clr,
    input  logic [CNT_W-1:0] init_val,
    input  logic [CNT_W-1:0] max_val,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf,
    output logic             evt
);
    logic count_on, wrap_hit;

    assign count_on = en && (mode == MODE_COUNT);
    assign wrap_hit = count_on && qual_edge && (cnt == max_val);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!count_on) begin
            cnt <= init_val;
        end else if (qual_edge) begin
            if (cnt == max_val) cnt <= init_val;
            else                cnt <= cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf <= 1'b0;
            evt <= 1'b0;
        end else begin
            ovf <= wrap_hit | (ovf & ~clr);
            evt <= en && (mode == MODE_DETECT) && qual_edge;
        end
    end

    // R9
    ovf_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> cnt == $past(init_val));

    // R10
    ovf_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> ($past(en) && $past(mode) == MODE_COUNT));

    // R12
    evt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> ($past(en) && $past(mode) == MODE_DETECT));

endmodule

// File: rtl/icap_channel.sv
module icap_channel
    import icap_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [1:0]       mode,
    input  logic             start_pol,
    input  logic             sig_in,
    input  logic [CNT_W-1:0] tbase,
    input  logic [CNT_W-1:0] cnt_init,
    input  logic [CNT_W-1:0] cnt_max,
    input  logic             rd_ack,
    output logic [CNT_W-1:0] meas_val,
    output logic             meas_rdy,
    output logic [CNT_W-1:0] ecnt,
    output logic             ecnt_ovf,
    output logic             edge_evt
);
    icap_mode_e mode_e;
    logic       rise, fall, open_edge, close_edge, measuring;

    assign mode_e     = icap_mode_e'(mode);
    assign open_edge  = start_pol ? rise : fall;
    assign close_edge = start_pol ? fall : rise;
    assign measuring  = en && (mode_e == MODE_WIDTH || mode_e == MODE_PERIOD);

    icap_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (sig_in),
        .rise (rise),
        .fall (fall)
    );

    icap_meas_fsm #(.CNT_W(CNT_W)) u_meas (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (measuring),
        .period_mode(mode_e == MODE_PERIOD),
        .open_edge  (open_edge),
        .close_edge (close_edge),
        .rd_ack     (rd_ack),
        .tbase      (tbase),
        .rdy        (meas_rdy),
        .result     (meas_val)
    );

    icap_event_unit #(.CNT_W(CNT_W)) u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .mode     (mode_e),
        .qual_edge(open_edge),
        .clr      (rd_ack),
        .init_val (cnt_init),
        .max_val  (cnt_max),
        .cnt      (ecnt),
        .ovf      (ecnt_ovf),
        .evt      (edge_evt)
    );

    // R11
    dis_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!edge_evt && !$rose(meas_rdy)));

endmodule

// File: tb/icap_channel_tb.sv
`timescale 1ns/1ps
module icap_channel_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 1'b0;
    logic [1:0]   mode = 2'b00;
    logic         start_pol = 1'b1;
    logic         sig_in = 1'b0;
    logic [W-1:0] tb_time = '0;
    logic [W-1:0] cnt_init = '0;
    logic [W-1:0] cnt_max = '1;
    logic         rd_ack = 1'b0;
    logic [W-1:0] meas_val;
    logic         meas_rdy;
    logic [W-1:0] ecnt;
    logic         ecnt_ovf;
    logic         edge_evt;

    int n_chk = 0;
    int n_err = 0;
    int evt_count = 0;
    logic [W-1:0] exp_v[$];
    string        exp_t[$];

    always #4 clk = ~clk;

    always @(posedge clk) begin
        tb_time <= tb_time + 1'b1;
        if (edge_evt) evt_count <= evt_count + 1;
    end

    icap_channel #(.CNT_W(W), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .start_pol(start_pol),
        .sig_in(sig_in), .tbase(tb_time), .cnt_init(cnt_init), .cnt_max(cnt_max),
        .rd_ack(rd_ack), .meas_val(meas_val), .meas_rdy(meas_rdy), .ecnt(ecnt),
        .ecnt_ovf(ecnt_ovf), .edge_evt(edge_evt)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push_exp(input int v, input string tag);
        exp_v.push_back(v[W-1:0]);
        exp_t.push_back(tag);
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // active phase of act_len cycles, then idle of idle_len; queue the active length
    task automatic pulse(input logic act, input int act_len, input int idle_len, input string tag);
        sig_in = act;
        cycles(act_len);
        sig_in = ~act;
        push_exp(act_len, tag);
        cycles(idle_len);
    endtask

    task automatic qual_rise();
        sig_in = 1'b1;
        cycles(4);
        sig_in = 1'b0;
        cycles(4);
    endtask

    // monitor: pops the scoreboard on every flagged result and acknowledges it
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && meas_rdy) begin
                if (exp_v.size() == 0) begin
                    chk("R4 unexpected result", int'(meas_val), -1);
                end else begin
                    automatic logic [W-1:0] v = exp_v.pop_front();
                    automatic string t = exp_t.pop_front();
                    chk(t, int'(meas_val), int'(v));
                end
                rd_ack = 1'b1;
                @(negedge clk);
                rd_ack = 1'b0;
                chk("R7 valid cleared by read", int'(meas_rdy), 0);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        int ev0;
        int per_hi[4] = '{6, 14, 4, 20};
        int per_lo[4] = '{4, 6, 9, 10};
        cycles(5);
        rst_n = 1'b1;
        cycles(1);
        // R1 reset state
        chk("R1 meas_rdy", int'(meas_rdy), 0);
        chk("R1 meas_val", int'(meas_val), 0);
        chk("R1 ecnt_ovf", int'(ecnt_ovf), 0);
        chk("R1 edge_evt", int'(edge_evt), 0);

        // R3 width mode, high time
        mode = 2'b00; start_pol = 1'b1; en = 1'b1;
        cycles(4);
        pulse(1'b1, 12, 9, "R3 high width");
        // R4 previous width still shown mid-pulse, no new flag
        sig_in = 1'b1;
        cycles(10);
        chk("R4 value held during pulse", int'(meas_val), 12);
        chk("R4 no flag before closing edge", int'(meas_rdy), 0);
        cycles(15);
        sig_in = 1'b0;
        push_exp(25, "R4 late width");
        cycles(8);
        pulse(1'b1, 5, 20, "R3 short width");
        // R6 measurement across the timebase wrap
        while (tb_time != 8'd200) @(negedge clk);
        pulse(1'b1, 120, 10, "R6 wrapped width");

        // R3 low-time width with falling start
        en = 1'b0;
        cycles(3);
        start_pol = 1'b0;
        sig_in = 1'b1;
        cycles(5);
        en = 1'b1;
        cycles(4);
        pulse(1'b0, 17, 10, "R3 low width");
        en = 1'b0;
        sig_in = 1'b0;
        cycles(6);

        // R5 period mode, varying periods
        mode = 2'b01; start_pol = 1'b1; en = 1'b1;
        cycles(4);
        for (int i = 0; i < 4; i++) begin
            sig_in = 1'b1;
            if (i > 0) push_exp(per_hi[i-1] + per_lo[i-1], "R5 period");
            cycles(per_hi[i]);
            sig_in = 1'b0;
            cycles(per_lo[i]);
        end
        sig_in = 1'b1;
        push_exp(per_hi[3] + per_lo[3], "R5 period");
        cycles(5);
        sig_in = 1'b0;
        cycles(10);
        chk("R10 no overflow in measurement modes", int'(ecnt_ovf), 0);
        chk("R5 all results seen", exp_v.size(), 0);
        en = 1'b0;
        cycles(4);

        // R11 edges while disabled are not flagged
        mode = 2'b11;
        ev0 = evt_count;
        for (int i = 0; i < 3; i++) qual_rise();
        cycles(3);
        en = 1'b1;
        cycles(5);
        chk("R11 no pulse from disabled edges", evt_count - ev0, 0);
        // R2 two-flop latency of the detect pulse
        sig_in = 1'b1;
        cycles(1);
        chk("R2 no pulse after edge k", int'(edge_evt), 0);
        cycles(1);
        chk("R2 no pulse after edge k+1", int'(edge_evt), 0);
        cycles(1);
        chk("R2 pulse after edge k+2", int'(edge_evt), 1);
        cycles(1);
        chk("R12 pulse lasts one cycle", int'(edge_evt), 0);
        ev0 = evt_count;
        sig_in = 1'b0;
        cycles(6);
        chk("R12 falling edge not flagged", evt_count - ev0, 0);
        for (int i = 0; i < 3; i++) qual_rise();
        chk("R12 one pulse per rising edge", evt_count - ev0, 3);
        en = 1'b0;
        cycles(4);

        // R8 / R9 edge counting with reload
        mode = 2'b10; cnt_init = 8'd250; cnt_max = 8'd253;
        qual_rise();
        qual_rise();
        en = 1'b1;
        cycles(3);
        chk("R11 disabled edges not counted", int'(ecnt), 250);
        qual_rise();
        chk("R8 first count", int'(ecnt), 251);
        qual_rise();
        qual_rise();
        chk("R8 count at max", int'(ecnt), 253);
        chk("R9 no overflow before wrap", int'(ecnt_ovf), 0);
        qual_rise();
        chk("R9 reload to initial value", int'(ecnt), 250);
        chk("R9 overflow set", int'(ecnt_ovf), 1);
        rd_ack = 1'b1;
        cycles(1);
        rd_ack = 1'b0;
        chk("R7 overflow cleared by read", int'(ecnt_ovf), 0);
        chk("R8 count mode posts no result", int'(meas_rdy), 0);
        en = 1'b0;
        cycles(5);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule